// File: doc/BRIEF.md
# Paged Address Translation Map

The block sits between a network controller, a host bus window and a small on-board RAM. A network controller issues 24-bit addresses. The block drops the top four bits. It splits the remaining 20 bits into a page index and a byte offset within the page. The index selects one 16-bit entry of a writable 1024-entry map. That entry gives a physical frame number, a flag that asks for the bytes of 16-bit data to be swapped, and a flag that sends the access to expansion memory instead of on-board RAM.

Two lookup ports share the one map: one for the controller and one for the host memory window. Because of this, both requesters always see the same placement of every page. Software programs the map through a 16-bit host register port that reads or writes one entry per request. Lookups win over host map accesses, so a host access waits while any lookup is presented. The last entry covers the top of the address space, where the controller fetches its fixed configuration pointer. Pointing that entry at a low frame makes one physical page appear at two addresses.

Top module: `page_xlate_map`

## Requirements
- R1: Bits 23:20 of a lookup address have no effect. Bits 19:10 select the map entry and bits 9:0 are the byte offset.
- R2: The physical address output is {frame, offset}: 22 bits, with the frame taken from entry bits 11:0 above the 10-bit offset.
- R3: Entry bit 15 drives the swap output (1 = big-endian swapped data, 0 = little-endian).
- R4: Entry bit 13 drives the expansion output (1 = expansion memory, 0 = on-board RAM).
- R5: The out-of-range output is 1 exactly when bit 13 is 0 and the frame is 256 or more. It is never 1 together with the expansion output.
- R6: After reset every map entry reads zero, and all lookup outputs are zero until the first lookup.
- R7: Entry bits 14 and 12 read back as written and change no lookup output.
- R8: A host read returns the addressed entry. With no lookup presented, the acknowledge and the read data come one cycle after the request.
- R9: A host write is seen by a lookup presented in the cycle after its acknowledge.
- R10: While either lookup valid is high, no host access is acknowledged. A lookup in the same cycle as a stalled host write sees the old entry.
- R11: Both lookup ports use the same map. With the last entry written to frame 0, controller address 0xFFFFF4 and window address 0x0003F4 give the same physical address.
- R12: Lookup results are registered. Each output valid rises one cycle after its input valid, and the result holds until the next lookup on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host map access request, held until acknowledged |
| host_we | input | 1 | 1 = write entry, 0 = read entry |
| host_idx | input | 10 | Map entry index |
| host_wdata | input | 16 | Entry value to write |
| host_rdata | output | 16 | Entry value read |
| host_ack | output | 1 | One-cycle acknowledge of the host access |
| ctl_vld | input | 1 | Controller lookup valid |
| ctl_addr | input | 24 | Controller address |
| ctl_out_vld | output | 1 | Controller result valid |
| ctl_paddr | output | 22 | Controller physical address |
| ctl_swap | output | 1 | Controller byte-swap flag |
| ctl_exp | output | 1 | Controller expansion-memory flag |
| ctl_oor | output | 1 | Controller out-of-range flag |
| win_vld | input | 1 | Host window lookup valid |
| win_addr | input | 24 | Host window address |
| win_out_vld | output | 1 | Window result valid |
| win_paddr | output | 22 | Window physical address |
| win_swap | output | 1 | Window byte-swap flag |
| win_exp | output | 1 | Window expansion-memory flag |
| win_oor | output | 1 | Window out-of-range flag |

## Verification
Each lookup result is due in the cycle after its valid is taken. The bench drives inputs on the falling edge and samples just after the next rising edge, with no lookup on the other port unless the test asks for one. A host acknowledge is due one edge after the request when no lookup is present. The host task counts the edges up to the acknowledge, so the stall case checks the exact one-cycle delay. A map write is checked by a lookup placed in the cycle right after the acknowledge. The same-cycle case checks that the lookup returns the entry's old value.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int ADDR_W  = 24;
  localparam int OFF_W   = 10;
  localparam int IDX_W   = 10;
  localparam int ENTRY_W = 16;
  localparam int FRAME_W = 12;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int DEPTH   = 1 << IDX_W;
  localparam int ONBOARD_PAGES = 256;
  localparam int SWAP_BIT = 15;
  localparam int EXP_BIT  = 13;

  typedef struct packed {
    logic [PA_W-1:0] paddr;
    logic            swap;
    logic            expm;
    logic            oor;
  } xlate_res_t;

  function automatic xlate_res_t decode_entry(input logic [ENTRY_W-1:0] ent,
                                              input logic [OFF_W-1:0] off);
    xlate_res_t r;
    r.paddr = {ent[FRAME_W-1:0], off};
    r.swap  = ent[SWAP_BIT];
    r.expm  = ent[EXP_BIT];
    r.oor   = !ent[EXP_BIT] && (ent[FRAME_W-1:0] >= FRAME_W'(ONBOARD_PAGES));
    return r;
  endfunction
endpackage

// File: rtl/pmap_table.sv
module pmap_table #(
  parameter int IDX_W   = 10,
  parameter int ENTRY_W = 16,
  parameter int NRD     = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [IDX_W-1:0]              widx,
  input  logic [ENTRY_W-1:0]            wdata,
  input  logic [NRD-1:0][IDX_W-1:0]     ridx,
  output logic [NRD-1:0][ENTRY_W-1:0]   rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[ridx[g]];
  end

  // R9
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we) |-> mem[$past(widx)] == $past(wdata));
endmodule

// File: rtl/pmap_arb.sv
module pmap_arb #(
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic               lookup_any,
  input  logic [ENTRY_W-1:0] entry_rd,
  output logic               grant,
  output logic               ack,
  output logic [ENTRY_W-1:0] rdata
);
  logic               ack_q, ack_d;
  logic [ENTRY_W-1:0] rdata_q, rdata_d;

  always_comb begin
    grant   = host_req && !lookup_any && !ack_q;
    ack_d   = grant;
    rdata_d = (grant && !host_we) ? entry_rd : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
    end
  end

  assign ack   = ack_q;
  assign rdata = rdata_q;

  // R8
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(host_req));
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
  import pmap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [ADDR_W-1:0]  in_addr,
  output logic [IDX_W-1:0]   entry_idx,
  input  logic [ENTRY_W-1:0] entry,
  output logic               out_vld,
  output logic [PA_W-1:0]    out_paddr,
  output logic               out_swap,
  output logic               out_exp,
  output logic               out_oor
);
  localparam int USED_W = OFF_W + IDX_W;

  logic [OFF_W-1:0] off;
  xlate_res_t       res_d, res_q;
  logic             vld_q;
  logic             unused_addr_hi;
  logic             unused_rsvd;

  assign unused_addr_hi = ^in_addr[ADDR_W-1:USED_W];
  assign unused_rsvd    = entry[14] ^ entry[12];

  assign entry_idx = in_addr[USED_W-1:OFF_W];
  assign off       = in_addr[OFF_W-1:0];

  always_comb begin
    res_d = in_vld ? decode_entry(entry, off) : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= in_vld;
    end
  end

  assign out_vld   = vld_q;
  assign out_paddr = res_q.paddr;
  assign out_swap  = res_q.swap;
  assign out_exp   = res_q.expm;
  assign out_oor   = res_q.oor;

  // R12
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld));
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_paddr[OFF_W-1:0] == $past(in_addr[OFF_W-1:0]));
  // R5
  oor_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_oor |-> (!out_exp && out_paddr[PA_W-1:OFF_W] >= FRAME_W'(ONBOARD_PAGES)));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_vld) |-> $stable(out_paddr));
endmodule

// File: rtl/page_xlate_map.sv
module page_xlate_map
  import pmap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [IDX_W-1:0]   host_idx,
  input  logic [ENTRY_W-1:0] host_wdata,
  output logic [ENTRY_W-1:0] host_rdata,
  output logic               host_ack,
  input  logic               ctl_vld,
  input  logic [ADDR_W-1:0]  ctl_addr,
  output logic               ctl_out_vld,
  output logic [PA_W-1:0]    ctl_paddr,
  output logic               ctl_swap,
  output logic               ctl_exp,
  output logic               ctl_oor,
  input  logic               win_vld,
  input  logic [ADDR_W-1:0]  win_addr,
  output logic               win_out_vld,
  output logic [PA_W-1:0]    win_paddr,
  output logic               win_swap,
  output logic               win_exp,
  output logic               win_oor
);
  localparam int NLK = 2;
  localparam int NRD = NLK + 1;

  logic [NRD-1:0][IDX_W-1:0]   ridx;
  logic [NRD-1:0][ENTRY_W-1:0] rent;
  logic                        grant;
  logic                        lookup_any;
  logic                        tbl_we;

  logic [NLK-1:0]              lk_vld;
  logic [NLK-1:0][ADDR_W-1:0]  lk_addr;
  logic [NLK-1:0]              o_vld, o_swap, o_exp, o_oor;
  logic [NLK-1:0][PA_W-1:0]    o_paddr;

  assign lk_vld     = {win_vld, ctl_vld};
  assign lk_addr    = {win_addr, ctl_addr};
  assign lookup_any = |lk_vld;
  assign tbl_we     = grant && host_we;
  assign ridx[NLK]  = host_idx;

  for (genvar g = 0; g < NLK; g++) begin : g_lk
    pmap_xlate u_xlate (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (lk_vld[g]),
      .in_addr   (lk_addr[g]),
      .entry_idx (ridx[g]),
      .entry     (rent[g]),
      .out_vld   (o_vld[g]),
      .out_paddr (o_paddr[g]),
      .out_swap  (o_swap[g]),
      .out_exp   (o_exp[g]),
      .out_oor   (o_oor[g])
    );
  end

  pmap_table #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .NRD(NRD)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .widx  (host_idx),
    .wdata (host_wdata),
    .ridx  (ridx),
    .rdata (rent)
  );

  pmap_arb #(.ENTRY_W(ENTRY_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .lookup_any (lookup_any),
    .entry_rd   (rent[NLK]),
    .grant      (grant),
    .ack        (host_ack),
    .rdata      (host_rdata)
  );

  assign ctl_out_vld = o_vld[0];
  assign ctl_paddr   = o_paddr[0];
  assign ctl_swap    = o_swap[0];
  assign ctl_exp     = o_exp[0];
  assign ctl_oor     = o_oor[0];
  assign win_out_vld = o_vld[1];
  assign win_paddr   = o_paddr[1];
  assign win_swap    = o_swap[1];
  assign win_exp     = o_exp[1];
  assign win_oor     = o_oor[1];

  // R10
  lookup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(!(ctl_vld || win_vld)));
  // R5
  ctl_oor_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_oor && ctl_exp) && !(win_oor && win_exp));
endmodule

// File: tb/page_xlate_map_test.sv
module page_xlate_map_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [9:0]  host_idx;
  logic [15:0] host_wdata, host_rdata;
  logic        host_ack;
  logic        ctl_vld, win_vld;
  logic [23:0] ctl_addr, win_addr;
  logic        ctl_out_vld, ctl_swap, ctl_exp, ctl_oor;
  logic        win_out_vld, win_swap, win_exp, win_oor;
  logic [21:0] ctl_paddr, win_paddr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate_map uut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] exp_pa(input logic [15:0] ent, input logic [23:0] a);
    return {ent[11:0], a[9:0]};
  endfunction

  task automatic host_op(input bit we, input logic [9:0] idx, input logic [15:0] wd,
                         output logic [15:0] rd, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_idx = idx; host_wdata = wd;
    lat = 0;
    do begin
      @(posedge clk); #1; lat++;
    end while (!host_ack && lat < 20);
    rd = host_rdata;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic map_wr(input logic [9:0] idx, input logic [15:0] wd);
    logic [15:0] rd; int lat;
    host_op(1'b1, idx, wd, rd, lat);
  endtask

  task automatic ctl_look(input logic [23:0] a);
    @(negedge clk);
    ctl_vld = 1'b1; ctl_addr = a;
    @(posedge clk); #1;
    @(negedge clk);
    ctl_vld = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] rd; int lat;
    chk(ctl_out_vld == 0 && ctl_paddr == 0 && ctl_swap == 0 && ctl_oor == 0, "R6 ctl outputs", ctl_paddr, 0);
    chk(win_out_vld == 0 && win_paddr == 0 && win_exp == 0, "R6 win outputs", win_paddr, 0);
    host_op(1'b0, 10'd777, 16'h0, rd, lat);
    chk(rd == 16'h0, "R6 entry zero", rd, 0);
    chk(lat == 1, "R8 read latency", lat, 1);
  endtask

  task automatic t_split_flags;
    logic [15:0] rd; int lat;
    map_wr(10'h048, 16'h80A5);
    host_op(1'b0, 10'h048, 16'h0, rd, lat);
    chk(rd == 16'h80A5, "R8 readback", rd, 16'h80A5);
    ctl_look(24'h012345);
    chk(ctl_out_vld == 1, "R12 out valid", ctl_out_vld, 1);
    chk(ctl_paddr == exp_pa(16'h80A5, 24'h012345), "R2 paddr", ctl_paddr, exp_pa(16'h80A5, 24'h012345));
    chk(ctl_swap == 1 && ctl_exp == 0, "R3 swap set", ctl_swap, 1);
    ctl_look(24'hF12345);
    chk(ctl_paddr == exp_pa(16'h80A5, 24'h012345), "R1 top bits ignored", ctl_paddr, exp_pa(16'h80A5, 24'h012345));
    @(negedge clk); @(negedge clk);
    chk(ctl_out_vld == 0 && ctl_paddr == exp_pa(16'h80A5, 24'h012345), "R12 hold", ctl_paddr, exp_pa(16'h80A5, 24'h012345));
    map_wr(10'h048, 16'h20A5);
    ctl_look(24'h012345);
    chk(ctl_swap == 0 && ctl_exp == 1, "R4 expansion set", {ctl_swap, ctl_exp}, 2'b01);
  endtask

  task automatic t_oor;
    map_wr(10'd5, 16'h0100);
    map_wr(10'd6, 16'h2100);
    map_wr(10'd7, 16'h00FF);
    ctl_look({4'h0, 10'd5, 10'h011});
    chk(ctl_oor == 1, "R5 frame 256 onboard", ctl_oor, 1);
    ctl_look({4'h0, 10'd6, 10'h011});
    chk(ctl_oor == 0 && ctl_exp == 1, "R5 expansion no oor", ctl_oor, 0);
    ctl_look({4'h0, 10'd7, 10'h011});
    chk(ctl_oor == 0 && ctl_paddr == {12'h0FF, 10'h011}, "R5 frame 255", ctl_paddr, {12'h0FF, 10'h011});
  endtask

  task automatic t_reserved;
    logic [15:0] rd; int lat;
    map_wr(10'd9, 16'h5033);
    host_op(1'b0, 10'd9, 16'h0, rd, lat);
    chk(rd == 16'h5033, "R7 reserved readback", rd, 16'h5033);
    ctl_look({4'h0, 10'd9, 10'h2AA});
    chk(ctl_paddr == {12'h033, 10'h2AA} && ctl_swap == 0 && ctl_exp == 0 && ctl_oor == 0,
        "R7 reserved no effect", ctl_paddr, {12'h033, 10'h2AA});
  endtask

  task automatic t_stall_and_visibility;
    int lat;
    map_wr(10'd20, 16'h0011);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_idx = 10'd20; host_wdata = 16'h0022;
    ctl_vld = 1'b1; ctl_addr = {4'h0, 10'd20, 10'h001};
    @(posedge clk); #1;
    chk(host_ack == 0, "R10 host stalled", host_ack, 0);
    chk(ctl_paddr == {12'h011, 10'h001}, "R10 lookup sees old entry", ctl_paddr, {12'h011, 10'h001});
    @(negedge clk);
    ctl_vld = 1'b0;
    lat = 0;
    do begin @(posedge clk); #1; lat++; end while (!host_ack && lat < 20);
    chk(lat == 1, "R10 one-cycle stall", lat, 1);
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    ctl_vld = 1'b1;
    @(posedge clk); #1;
    chk(ctl_paddr == {12'h022, 10'h001}, "R9 write visible next cycle", ctl_paddr, {12'h022, 10'h001});
    @(negedge clk);
    ctl_vld = 1'b0;
  endtask

  task automatic t_alias;
    map_wr(10'd1023, 16'h8000);
    map_wr(10'd0, 16'h8000);
    @(negedge clk);
    ctl_vld = 1'b1; ctl_addr = 24'hFFFFF4;
    win_vld = 1'b1; win_addr = 24'h0003F4;
    @(posedge clk); #1;
    chk(ctl_paddr == 22'h3F4 && ctl_swap == 1, "R11 ctl alias", ctl_paddr, 22'h3F4);
    chk(win_paddr == ctl_paddr && win_out_vld == 1 && win_swap == 1, "R11 window same page", win_paddr, ctl_paddr);
    @(negedge clk);
    ctl_vld = 1'b0; win_vld = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; host_req = 0; host_we = 0; host_idx = 0; host_wdata = 0;
    ctl_vld = 0; win_vld = 0; ctl_addr = 0; win_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_split_flags();
    t_oor();
    t_reserved();
    t_stall_and_visibility();
    t_alias();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule